// File: doc/BRIEF.md
# Multi-cycle accumulator sequencer

This block is a small processor core built around an 8-bit accumulator. Besides the accumulator it holds two general registers (B and C), a program counter, a memory address register, a memory buffer register, an instruction register and two condition flags: zero and carry. A step counter drives every instruction through a fixed sequence of one-cycle steps. The first three steps fetch the opcode and are the same for every instruction. The counter is cleared to the first step when an instruction completes, so the next fetch follows with no gap.

The core addresses a 256-byte memory. The address it drives always comes from the memory address register, and it expects the read data back in the same cycle. Writes happen only in store instructions and only with the write enable high. Two debug outputs show the accumulator and the program counter, and a halted output reports that an undefined opcode has stopped the core. The instruction set has twenty opcodes: register moves, an immediate load, direct load and store, register and immediate ALU operations, a compare, and absolute jumps (unconditional, on carry, on zero).

Top module: `accu_core`

## Requirements
- R1: A synchronous reset clears the program counter, A, B, C, both flags and the halted state, and returns the step counter to the first step. Execution then starts with a fetch at address 00h, and `mem_we` stays low.
- R2: Every instruction begins with a three-step fetch that puts PC on `mem_addr`, reads the opcode and increments PC. Each class takes a fixed total number of cycles: moves 5, register ALU and compare 6, MVI 7, immediate ALU 8, LDA and STA 9, JMP and a taken JC or JZ 7, an untaken JC or JZ 5. An undefined opcode reaches the halted state in 4 cycles.
- R3: The moves are: 00h copies B into A, 01h copies A into B, 02h copies C into B. Opcode 03h followed by a byte loads that byte into A. None of these instructions changes the flags. No opcode writes C, so C holds its reset value of 00h.
- R4: The arithmetic opcodes write their result to A and set Z when that result is zero: 06h adds B, 07h adds an immediate byte, 08h subtracts B, 09h subtracts an immediate byte, 0Ah increments, 0Bh decrements. Carry is set by a carry out of an add or increment, and by a borrow in a subtract or decrement.
- R5: The logic opcodes write their result to A, clear carry and set Z when the result is zero: 0Ch ANDs B, 0Dh ORs C, 0Fh XORs B, 10h ANDs an immediate byte.
- R6: Opcode 0Eh computes A minus B and sets Z and carry as a subtract would. A keeps its value.
- R7: Opcode 04h followed by an address loads A from that address. Opcode 05h followed by an address writes A to that address. The write raises `mem_we` for exactly one cycle, with `mem_addr` holding the target address and `mem_wdata` holding A.
- R8: Opcode 11h followed by an address loads PC with that address. Opcode 12h does the same when carry is 1, and opcode 13h does the same when Z is 1.
- R9: When the flag tested by 12h or 13h is 0, the address byte is skipped and execution continues at the byte after it.
- R10: Any opcode above 13h raises `halted` and stops the step counter. From then until reset, PC and A do not change and `mem_we` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 8 | Read data of the byte at `mem_addr`, valid in the same cycle |
| mem_addr | output | 8 | Memory address, taken from the address register |
| mem_wdata | output | 8 | Write data, taken from the buffer register |
| mem_we | output | 1 | Write strobe for the byte at `mem_addr` |
| halted | output | 1 | High after an undefined opcode, until reset |
| dbg_a | output | 8 | Accumulator contents |
| dbg_pc | output | 8 | Program counter contents |

## Verification
Each instruction takes a fixed number of cycles that depends only on its class and, for a conditional jump, on the tested flag. The bench therefore adds up those cycle counts for every program it builds and counts the clock edges from reset release to the edge that raises `halted`. A step lost or added anywhere in the sequence shows up as a wrong count. Results and flags are not read as they change. The bench reads them after the core has halted: stores leave A in memory, and conditional jumps turn each flag into a stored marker byte. The flags survive the moves and immediate loads that the epilogue uses, so each value reaches memory at a known point.

// File: rtl/accu_pkg.sv
package accu_pkg;

    localparam int STEP_W = 4;

    localparam logic [STEP_W-1:0] T1 = 4'd0;
    localparam logic [STEP_W-1:0] T2 = 4'd1;
    localparam logic [STEP_W-1:0] T3 = 4'd2;
    localparam logic [STEP_W-1:0] T4 = 4'd3;
    localparam logic [STEP_W-1:0] T5 = 4'd4;
    localparam logic [STEP_W-1:0] T6 = 4'd5;
    localparam logic [STEP_W-1:0] T7 = 4'd6;
    localparam logic [STEP_W-1:0] T8 = 4'd7;

    typedef enum logic [3:0] {
        CL_MOV_AB, CL_MOV_BA, CL_MOV_BC, CL_MVI, CL_LDA, CL_STA,
        CL_ALU_REG, CL_ALU_IMM, CL_JMP, CL_JC, CL_JZ, CL_BAD
    } op_class_e;

    typedef enum logic [2:0] {
        AOP_ADD, AOP_SUB, AOP_INC, AOP_DEC, AOP_AND, AOP_OR, AOP_XOR
    } alu_op_e;

    typedef struct packed {
        op_class_e cls;
        alu_op_e   aop;
        logic      use_c;   // register operand is C instead of B
        logic      no_wb;   // flags only, accumulator untouched
    } dec_t;

endpackage

// File: rtl/accu_decode.sv
module accu_decode
    import accu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opcode,
    output dec_t              dec
);
    localparam int SEL_W = 5;

    logic hi_zero;
    assign hi_zero = (opcode[DATA_W-1:SEL_W] == '0);

    always_comb begin
        dec = '{cls: CL_BAD, aop: AOP_ADD, use_c: 1'b0, no_wb: 1'b0};
        if (hi_zero) begin
            case (opcode[SEL_W-1:0])
                5'h00: dec.cls = CL_MOV_AB;
                5'h01: dec.cls = CL_MOV_BA;
                5'h02: dec.cls = CL_MOV_BC;
                5'h03: dec.cls = CL_MVI;
                5'h04: dec.cls = CL_LDA;
                5'h05: dec.cls = CL_STA;
                5'h06: begin dec.cls = CL_ALU_REG; dec.aop = AOP_ADD; end
                5'h07: begin dec.cls = CL_ALU_IMM; dec.aop = AOP_ADD; end
                5'h08: begin dec.cls = CL_ALU_REG; dec.aop = AOP_SUB; end
                5'h09: begin dec.cls = CL_ALU_IMM; dec.aop = AOP_SUB; end
                5'h0A: begin dec.cls = CL_ALU_REG; dec.aop = AOP_INC; end
                5'h0B: begin dec.cls = CL_ALU_REG; dec.aop = AOP_DEC; end
                5'h0C: begin dec.cls = CL_ALU_REG; dec.aop = AOP_AND; end
                5'h0D: begin dec.cls = CL_ALU_REG; dec.aop = AOP_OR; dec.use_c = 1'b1; end
                5'h0E: begin dec.cls = CL_ALU_REG; dec.aop = AOP_SUB; dec.no_wb = 1'b1; end
                5'h0F: begin dec.cls = CL_ALU_REG; dec.aop = AOP_XOR; end
                5'h10: begin dec.cls = CL_ALU_IMM; dec.aop = AOP_AND; end
                5'h11: dec.cls = CL_JMP;
                5'h12: dec.cls = CL_JC;
                5'h13: dec.cls = CL_JZ;
                default: dec.cls = CL_BAD;
            endcase
        end
    end
endmodule

// File: rtl/accu_alu.sv
module accu_alu
    import accu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] ext;

    always_comb begin
        case (op)
            AOP_ADD: ext = {1'b0, x} + {1'b0, y};
            AOP_SUB: ext = {1'b0, x} - {1'b0, y};
            AOP_INC: ext = {1'b0, x} + EXT_W'(1);
            AOP_DEC: ext = {1'b0, x} - EXT_W'(1);
            AOP_AND: ext = {1'b0, x & y};
            AOP_OR:  ext = {1'b0, x | y};
            AOP_XOR: ext = {1'b0, x ^ y};
            default: ext = '0;
        endcase
        res  = ext[DATA_W-1:0];
        cout = ext[DATA_W];
    end
endmodule

// File: rtl/accu_core.sv
module accu_core
    import accu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              halted,
    output logic [DATA_W-1:0] dbg_a,
    output logic [DATA_W-1:0] dbg_pc
);
    typedef struct packed {
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] c;
        logic [DATA_W-1:0] tmp;
        logic              tmp_c;
        logic              zf;
        logic              cf;
        logic              halt;
        logic [STEP_W-1:0] step;
    } core_state_t;

    core_state_t st_q, st_d;
    dec_t        dec;
    logic [DATA_W-1:0] alu_y, alu_res;
    logic        alu_c;
    logic        is_jump, take, opnd;
    logic [STEP_W-1:0] step_w;

    accu_decode #(.DATA_W(DATA_W)) u_dec (
        .opcode (st_q.ir),
        .dec    (dec)
    );

    assign alu_y = (dec.cls == CL_ALU_IMM) ? st_q.mbr :
                   (dec.use_c ? st_q.c : st_q.b);

    accu_alu #(.DATA_W(DATA_W)) u_alu (
        .op   (dec.aop),
        .x    (st_q.a),
        .y    (alu_y),
        .res  (alu_res),
        .cout (alu_c)
    );

    assign is_jump = (dec.cls == CL_JMP) || (dec.cls == CL_JC) || (dec.cls == CL_JZ);
    assign take    = (dec.cls == CL_JMP) || (dec.cls == CL_JC && st_q.cf) ||
                     (dec.cls == CL_JZ && st_q.zf);
    assign opnd    = (dec.cls == CL_MVI) || (dec.cls == CL_ALU_IMM) ||
                     (dec.cls == CL_LDA) || (dec.cls == CL_STA) || (is_jump && take);

    always_comb begin
        st_d      = st_q;
        st_d.step = st_q.step + 1'b1;
        if (st_q.halt) begin
            st_d.step = st_q.step;
        end else begin
            case (st_q.step)
                T1: st_d.mar = st_q.pc;
                T2: begin
                    st_d.mbr = mem_rdata;
                    st_d.pc  = st_q.pc + 1'b1;
                end
                T3: st_d.ir = st_q.mbr;
                default: begin
                    if (dec.cls == CL_BAD) begin
                        st_d.halt = 1'b1;
                        st_d.step = st_q.step;
                    end else if (opnd && st_q.step == T4) begin
                        st_d.mar = st_q.pc;
                    end else if (opnd && st_q.step == T5) begin
                        st_d.mbr = mem_rdata;
                        if (!is_jump) st_d.pc = st_q.pc + 1'b1;
                    end else begin
                        case (dec.cls)
                            CL_MOV_AB, CL_MOV_BA, CL_MOV_BC: begin
                                if (st_q.step == T4) begin
                                    if (dec.cls == CL_MOV_AB)      st_d.a = st_q.b;
                                    else if (dec.cls == CL_MOV_BA) st_d.b = st_q.a;
                                    else                           st_d.b = st_q.c;
                                end else st_d.step = T1;
                            end
                            CL_ALU_REG, CL_ALU_IMM: begin
                                if (st_q.step == ((dec.cls == CL_ALU_REG) ? T4 : T6)) begin
                                    st_d.tmp   = alu_res;
                                    st_d.tmp_c = alu_c;
                                end else if (st_q.step == ((dec.cls == CL_ALU_REG) ? T5 : T7)) begin
                                    if (!dec.no_wb) st_d.a = st_q.tmp;
                                    st_d.zf = (st_q.tmp == '0);
                                    st_d.cf = st_q.tmp_c;
                                end else st_d.step = T1;
                            end
                            CL_MVI: begin
                                if (st_q.step == T6) st_d.a = st_q.mbr;
                                else                 st_d.step = T1;
                            end
                            CL_LDA, CL_STA: begin
                                if (st_q.step == T6) st_d.mar = st_q.mbr;
                                else if (st_q.step == T7) begin
                                    if (dec.cls == CL_LDA) st_d.mbr = mem_rdata;
                                    else                   st_d.mbr = st_q.a;
                                end else if (st_q.step == T8) begin
                                    if (dec.cls == CL_LDA) st_d.a = st_q.mbr;
                                end else st_d.step = T1;
                            end
                            default: begin
                                if (take) begin
                                    if (st_q.step == T6) st_d.pc = st_q.mbr;
                                    else                 st_d.step = T1;
                                end else begin
                                    if (st_q.step == T4) st_d.pc = st_q.pc + 1'b1;
                                    else                 st_d.step = T1;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mem_addr  = st_q.mar;
    assign mem_wdata = st_q.mbr;
    assign mem_we    = !st_q.halt && (dec.cls == CL_STA) && (st_q.step == T8);
    assign halted    = st_q.halt;
    assign dbg_a     = st_q.a;
    assign dbg_pc    = st_q.pc;
    assign step_w    = st_q.step;

endmodule

// File: rtl/accu_core_chk.sv
module accu_core_chk
    import accu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted,
    input logic [DATA_W-1:0] dbg_a,
    input logic [DATA_W-1:0] dbg_pc,
    input logic [STEP_W-1:0] step
);
    logic rst_q;
    initial rst_q = 1'b0;
    always @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q && !rst) begin
            AST_RESET_CLEARS: assert (dbg_pc == '0 && dbg_a == '0 && !halted && !mem_we); // R1
        end
    end

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
        (step == T2) |-> (mem_addr == $past(dbg_pc))); // R2

    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R7

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R10

    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we); // R10

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(dbg_pc) && $stable(dbg_a))); // R10

endmodule

bind accu_core accu_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halted   (halted),
    .dbg_a    (dbg_a),
    .dbg_pc   (dbg_pc),
    .step     (step_w)
);

// File: tb/accu_core_tb.sv
`timescale 1ns/1ps
module accu_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_rdata, mem_addr, mem_wdata, dbg_a, dbg_pc;
    logic       mem_we, halted;
    logic [7:0] mem [256];

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int we_halt = 0;
    int p = 0;

    always #4 clk = ~clk;

    accu_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .halted    (halted),
        .dbg_a     (dbg_a),
        .dbg_pc    (dbg_pc)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
            if (halted) we_halt <= we_halt + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        mem[p[7:0]] = b;
        p++;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        p = 0;
    endtask

    task automatic run(output int n);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        while (!halted && n < 1000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] opc(input int k);
        case (k)
            0: return 8'h06;  1: return 8'h08;  2: return 8'h0A;  3: return 8'h0B;
            4: return 8'h0C;  5: return 8'h0D;  6: return 8'h0E;  7: return 8'h0F;
            8: return 8'h07;  9: return 8'h09;  default: return 8'h10;
        endcase
    endfunction

    function automatic logic [7:0] val(input int i);
        case (i)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h7F; 3: return 8'h80;
            4: return 8'hFF; 5: return 8'h55; 6: return 8'hAA; default: return 8'h0F;
        endcase
    endfunction

    // {carry, result} from the requirement text; register C is 00h (R3)
    function automatic logic [8:0] ref_op(input int k, input logic [7:0] x, input logic [7:0] y);
        case (k)
            0, 8:    return {1'b0, x} + {1'b0, y};
            1, 6, 9: return {1'b0, x} - {1'b0, y};
            2:       return {1'b0, x} + 9'd1;
            3:       return {1'b0, x} - 9'd1;
            4, 10:   return {1'b0, x & y};
            5:       return {1'b0, x | 8'h00};
            7:       return {1'b0, x ^ y};
            default: return 9'd0;
        endcase
    endfunction

    // flag test block: stores 1 at dst when flag set, else 0
    task automatic flag_block(input logic [7:0] jop, input bit flag, input logic [7:0] dst, inout int cyc);
        int q;
        q = p;
        put(jop); put(8'(q + 6));
        put(8'h03); put(8'h00);
        put(8'h11); put(8'(q + 8));
        put(8'h03); put(8'h01);
        put(8'h05); put(dst);
        cyc += (flag ? 14 : 19) + 9;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, cyc, w0;
        logic [8:0] r;
        logic [7:0] x, y, a_exp;

        // R1: state while held in reset
        enter_reset();
        @(negedge clk);
        chk("R1", "pc in reset", dbg_pc, 0);
        chk("R1", "a in reset", dbg_a, 0);
        chk("R1", "halted in reset", halted, 0);
        chk("R1", "we in reset", mem_we, 0);

        // R3 and R7: moves, immediate load, direct load, stores
        enter_reset();
        put(8'h03); put(8'h05); put(8'h01); put(8'h03); put(8'h09); put(8'h00);
        put(8'h05); put(8'hF0); put(8'h02); put(8'h00); put(8'h05); put(8'hF1);
        put(8'h04); put(8'h80); put(8'h05); put(8'hF2); put(8'hFF);
        mem[8'h80] = 8'h3C;
        w0 = we_cnt;
        run(n);
        chk("R3", "mov a,b", mem[8'hF0], 8'h05);
        chk("R3", "mov b,c clears", mem[8'hF1], 8'h00);
        chk("R7", "lda then sta", mem[8'hF2], 8'h3C);
        chk("R7", "write strobes", we_cnt - w0, 3);
        chk("R2", "cycles moves/lda", n, 74);
        chk("R10", "pc after halt", dbg_pc, 8'h11);

        // R3: moves and immediate loads keep the carry from an add
        enter_reset();
        put(8'h03); put(8'hFF); put(8'h01); put(8'h06); put(8'h03); put(8'h00);
        put(8'h01); put(8'h00); put(8'h12); put(8'h0E); put(8'h03); put(8'h11);
        put(8'hFF); put(8'hFF); put(8'h03); put(8'h22); put(8'hFF);
        run(n);
        chk("R3", "carry kept by mvi/mov", dbg_a, 8'h22);
        chk("R2", "cycles flag keep", n, 7 + 5 + 6 + 7 + 5 + 5 + 7 + 7 + 4);

        // R8: unconditional jump
        enter_reset();
        put(8'h11); put(8'h06); put(8'h03); put(8'hAA); put(8'hFF); put(8'hFF);
        put(8'h03); put(8'hBB); put(8'hFF);
        run(n);
        chk("R8", "jmp target", dbg_a, 8'hBB);
        chk("R2", "cycles jmp", n, 18);

        // R10: lowest undefined opcode halts and freezes
        enter_reset();
        put(8'h03); put(8'h42); put(8'h14);
        run(n);
        chk("R10", "halted", halted, 1);
        chk("R2", "cycles halt", n, 11);
        repeat (10) @(negedge clk);
        chk("R10", "halted stays", halted, 1);
        chk("R10", "pc frozen", dbg_pc, 8'h03);
        chk("R10", "a frozen", dbg_a, 8'h42);
        chk("R10", "no write while halted", we_halt, 0);
        enter_reset();
        @(negedge clk);
        chk("R1", "reset leaves halt", halted, 0);

        // R4 R5 R6 R8 R9 R2: sweep of every ALU opcode over operand pairs
        for (int k = 0; k < 11; k++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    string rq;
                    x = val(i);
                    y = val(j);
                    r = ref_op(k, x, y);
                    a_exp = (k == 6) ? x : r[7:0];
                    rq = (k == 6) ? "R6" : ((k == 4 || k == 5 || k == 7 || k == 10) ? "R5" : "R4");
                    enter_reset();
                    cyc = 0;
                    if (k < 8) begin
                        put(8'h03); put(y); put(8'h01); put(8'h03); put(x); put(opc(k));
                        cyc += 7 + 5 + 7 + 6;
                    end else begin
                        put(8'h03); put(x); put(opc(k)); put(y);
                        cyc += 7 + 8;
                    end
                    put(8'h05); put(8'hF0);
                    cyc += 9;
                    flag_block(8'h12, r[8], 8'hF1, cyc);
                    flag_block(8'h13, (r[7:0] == 8'h00), 8'hF2, cyc);
                    put(8'hFF);
                    cyc += 4;
                    run(n);
                    chk(rq, $sformatf("op%0d A x=%0h y=%0h", k, x, y), mem[8'hF0], a_exp);
                    chk(rq, $sformatf("op%0d carry x=%0h y=%0h", k, x, y), mem[8'hF1], r[8]);
                    chk(rq, $sformatf("op%0d zero x=%0h y=%0h", k, x, y), mem[8'hF2], (r[7:0] == 8'h00));
                    // R8 taken / R9 untaken paths fix the cycle total
                    chk("R9", $sformatf("op%0d cycles x=%0h y=%0h", k, x, y), n, cyc);
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule